// File: doc/BRIEF.md
# Retriggerable Noise Blanking Pulse Former

This block converts a one-bit spike decision into an active-low hold pulse. The spike decision comes from an analog comparator, already synchronized to the system clock. The hold pulse freezes the sample-and-hold stage behind a stereo decoder, so the audio output keeps its present value while an ignition or motor spike passes. The hold lasts for a blanking time chosen from four values by a two-bit select. The time is counted in system clock cycles, and each value is rounded to the nearest cycle for the clock frequency given as a parameter.

The one-shot can be retriggered. Every fresh rising edge of the trigger during a pulse reloads the full interval, so a burst of spikes stretches the blanking until the burst ends. The select is read only when a trigger edge loads the counter. A separate enable turns the blanker off: while the enable is off, no pulse is issued, and dropping the enable ends any pulse in progress.

Top module: `nb_pulse_former`

## Requirements
- R1: After reset, `hold_n_o` is high and stays high until a qualifying trigger edge.
- R2: A rising edge on `trig_i`, sampled with `blank_en_i` high, drives `hold_n_o` low from the clock edge that samples it.
- R3: The hold stays low for exactly round(T × CLK_KHZ / 1000) cycles. T is 38 µs for select code 0, 25.5 µs for code 1, 32 µs for code 2 and 22 µs for code 3.
- R4: A new rising edge during an active pulse restarts the full interval from that edge, and the hold does not go high in between.
- R5: Only rising edges count: a trigger held high continuously yields one interval, and the hold then releases.
- R6: With `blank_en_i` low, trigger edges produce no pulse. Lowering `blank_en_i` during a pulse returns `hold_n_o` high at the next clock edge.
- R7: A change of `blank_sel_i` during an active pulse leaves that pulse's length unchanged. The next trigger edge uses the new code.
- R8: `hold_n_o` falls only at the clock edge after a qualifying trigger edge is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Synchronous spike-detect decision from the comparator |
| blank_en_i | input | 1 | Blanker enable; low suppresses and clears the hold |
| blank_sel_i | input | 2 | Blanking-time code, sampled on a trigger edge |
| hold_n_o | output | 1 | Active-low hold for the output sample-and-hold |

## Verification
A trigger edge sampled at clock edge k pulls `hold_n_o` low just after edge k. The pulse ends after edge k+N, where N is the cycle count the bench computes in floating point from the microsecond values. The bench drives inputs on the falling clock edge and samples 1 ns after each rising edge. It counts the low cycles and compares that count with N. Disable results are due one cycle after the enable falls and are sampled there. Retrigger and select-change cases count from the most recent qualifying edge.

// File: rtl/nb_pkg.sv
`timescale 1ns/1ps
package nb_pkg;

  // Blanking times in tenths of a microsecond, indexed by select code.
  function automatic int unsigned blank_tenths_us(input logic [1:0] code);
    case (code)
      2'd0:    return 380;
      2'd1:    return 255;
      2'd2:    return 320;
      default: return 220;
    endcase
  endfunction

  // Cycles for one code, rounded to nearest: tenths * kHz / 10000.
  function automatic int unsigned blank_cycles(input logic [1:0] code,
                                               input int unsigned clk_khz);
    return (blank_tenths_us(code) * clk_khz + 5000) / 10000;
  endfunction

  function automatic int unsigned max_blank_cycles(input int unsigned clk_khz);
    int unsigned m;
    m = 0;
    for (int i = 0; i < 4; i++) begin
      if (blank_cycles(2'(i), clk_khz) > m) m = blank_cycles(2'(i), clk_khz);
    end
    return m;
  endfunction

endpackage

// File: rtl/nb_edge_detect.sv
`timescale 1ns/1ps
module nb_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic gate_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q & gate_i;
endmodule

// File: rtl/nb_width_sel.sv
`timescale 1ns/1ps
module nb_width_sel #(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned CW      = 12
) (
  input  logic [1:0]    code_i,
  output logic [CW-1:0] cycles_o
);
  logic [CW-1:0] table_w [4];

  for (genvar g = 0; g < 4; g++) begin : g_entry
    localparam int unsigned ENTRY = nb_pkg::blank_cycles(2'(g), CLK_KHZ);
    assign table_w[g] = CW'(ENTRY);
  end

  assign cycles_o = table_w[code_i];
endmodule

// File: rtl/nb_hold_timer.sv
`timescale 1ns/1ps
module nb_hold_timer #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          clear_i,
  output logic [CW-1:0] count_o,
  output logic          active_o
);
  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count_q <= '0;
    else if (clear_i)        count_q <= '0;
    else if (load_i)         count_q <= load_val_i;
    else if (count_q != '0)  count_q <= count_q - CW'(1);
  end

  assign count_o  = count_q;
  assign active_o = (count_q != '0);
endmodule

// File: rtl/nb_pulse_former.sv
`timescale 1ns/1ps
module nb_pulse_former #(
  parameter int unsigned CLK_KHZ = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_i,
  input  logic       blank_en_i,
  input  logic [1:0] blank_sel_i,
  output logic       hold_n_o
);
  localparam int unsigned MAX_CYC = nb_pkg::max_blank_cycles(CLK_KHZ);
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  logic          trig_edge;
  logic [CW-1:0] load_val;
  logic [CW-1:0] count_q;
  logic          hold_active;

  nb_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (trig_i),
    .gate_i  (blank_en_i),
    .rise_o  (trig_edge)
  );

  nb_width_sel #(.CLK_KHZ(CLK_KHZ), .CW(CW)) u_wsel (
    .code_i   (blank_sel_i),
    .cycles_o (load_val)
  );

  nb_hold_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (trig_edge),
    .load_val_i (load_val),
    .clear_i    (~blank_en_i),
    .count_o    (count_q),
    .active_o   (hold_active)
  );

  assign hold_n_o = ~hold_active;
endmodule

// File: rtl/nb_pulse_former_chk.sv
`timescale 1ns/1ps
module nb_pulse_former_chk #(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned CW      = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blank_en_i,
  input logic          hold_n_o,
  input logic          trig_edge,
  input logic [CW-1:0] count_q
);
  localparam int unsigned W0 = nb_pkg::blank_cycles(2'd0, CLK_KHZ);
  localparam int unsigned W1 = nb_pkg::blank_cycles(2'd1, CLK_KHZ);
  localparam int unsigned W2 = nb_pkg::blank_cycles(2'd2, CLK_KHZ);
  localparam int unsigned W3 = nb_pkg::blank_cycles(2'd3, CLK_KHZ);

  p_edge_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge |=> !hold_n_o);

  p_load_in_table_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge |=> (count_q == CW'(W0) || count_q == CW'(W1) ||
                   count_q == CW'(W2) || count_q == CW'(W3)));

  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != '0 && !trig_edge && blank_en_i) |=>
      (count_q == $past(count_q) - CW'(1)));

  p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_en_i |=> hold_n_o);

  p_fall_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_n_o) |-> $past(trig_edge));
endmodule

bind nb_pulse_former nb_pulse_former_chk #(.CLK_KHZ(CLK_KHZ), .CW(CW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .blank_en_i (blank_en_i),
  .hold_n_o   (hold_n_o),
  .trig_edge  (trig_edge),
  .count_q    (count_q)
);

// File: tb/test_nb_pulse_former.sv
`timescale 1ns/1ps
module test_nb_pulse_former;
  localparam int unsigned CLK_KHZ = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig = 1'b0;
  logic       en = 1'b1;
  logic [1:0] sel = 2'd0;
  logic       hold_n;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  nb_pulse_former #(.CLK_KHZ(CLK_KHZ)) i_nb_pulse_former (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig),
    .blank_en_i  (en),
    .blank_sel_i (sel),
    .hold_n_o    (hold_n)
  );

  function automatic int expect_cycles(input logic [1:0] code);
    real us;
    case (code)
      2'd0: us = 38.0;
      2'd1: us = 25.5;
      2'd2: us = 32.0;
      default: us = 22.0;
    endcase
    return $rtoi(us * real'(CLK_KHZ) / 1000.0 + 0.5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fire();
    @(negedge clk); trig = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic release_trig();
    @(negedge clk); trig = 1'b0;
  endtask

  // Counts low cycles from now; samples 1 ns after each rising edge.
  task automatic count_low(output int n);
    n = 0;
    while (!hold_n && n < 20000) begin
      n++;
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset();
    check(hold_n === 1'b1, "R1 hold high in reset", int'(hold_n), 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk); #1;
    check(hold_n === 1'b1, "R1 hold high idle", int'(hold_n), 1);
  endtask

  task automatic t_width(input logic [1:0] code);
    int n;
    @(negedge clk); sel = code;
    fire();
    check(hold_n === 1'b0, "R2 hold low after edge", int'(hold_n), 0);
    release_trig();
    #1;
    n = 1;
    @(posedge clk); #1;
    while (!hold_n && n < 20000) begin n++; @(posedge clk); #1; end
    check(n == expect_cycles(code), "R3 width", n, expect_cycles(code));
    check(hold_n === 1'b1, "R8 hold high after pulse", int'(hold_n), 1);
  endtask

  task automatic t_retrigger();
    int n;
    bit gap;
    @(negedge clk); sel = 2'd3;
    fire(); release_trig();
    gap = 0;
    repeat (1000) begin @(posedge clk); #1; if (hold_n) gap = 1; end
    fire(); release_trig();
    check(!gap && hold_n === 1'b0, "R4 no gap before retrigger", int'(gap), 0);
    #1;
    n = 1;
    @(posedge clk); #1;
    while (!hold_n && n < 20000) begin n++; @(posedge clk); #1; end
    check(n == expect_cycles(2'd3), "R4 full interval after retrigger", n, expect_cycles(2'd3));
  endtask

  task automatic t_held_high();
    int n;
    @(negedge clk); sel = 2'd1;
    fire();
    count_low(n);
    check(n == expect_cycles(2'd1), "R5 held-high single interval", n, expect_cycles(2'd1));
    repeat (20) @(posedge clk); #1;
    check(hold_n === 1'b1, "R5 no extension while held", int'(hold_n), 1);
    release_trig();
  endtask

  task automatic t_disable();
    int lows;
    @(negedge clk); en = 1'b0;
    fire();
    lows = 0;
    repeat (10) begin if (!hold_n) lows++; @(posedge clk); #1; end
    check(lows == 0, "R6 no pulse when disabled", lows, 0);
    release_trig();
    @(negedge clk); en = 1'b1;
    fire(); release_trig();
    repeat (100) @(posedge clk); #1;
    check(hold_n === 1'b0, "R6 pulse active before disable", int'(hold_n), 0);
    @(negedge clk); en = 1'b0;
    @(posedge clk); #1;
    check(hold_n === 1'b1, "R6 disable ends pulse", int'(hold_n), 1);
    @(negedge clk); en = 1'b1;
    repeat (3) @(posedge clk); #1;
    check(hold_n === 1'b1, "R6 stays high after re-enable", int'(hold_n), 1);
  endtask

  task automatic t_sel_change();
    int n;
    @(negedge clk); sel = 2'd3;
    fire(); release_trig();
    #1;
    n = 1;
    @(posedge clk); #1;
    while (!hold_n && n < 20000) begin
      n++;
      if (n == 10) sel = 2'd0;
      @(posedge clk); #1;
    end
    check(n == expect_cycles(2'd3), "R7 active pulse keeps old width", n, expect_cycles(2'd3));
    fire(); release_trig();
    #1;
    n = 1;
    @(posedge clk); #1;
    while (!hold_n && n < 20000) begin n++; @(posedge clk); #1; end
    check(n == expect_cycles(2'd0), "R7 next trigger uses new width", n, expect_cycles(2'd0));
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    t_reset();
    for (int c = 0; c < 4; c++) t_width(2'(c));
    t_retrigger();
    t_held_high();
    t_disable();
    t_sel_change();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule